// File: doc/BRIEF.md
# Grouped Interrupt Vector Controller

This block gathers a wide set of edge-style interrupt vectors and presents them to a parent interrupt controller as a small number of summary lines. The vectors are banked into groups of 32. Each group holds two 32-bit words. One is a latch word, which records events and is cleared by writing ones to it. The other is a mask word, which is plain read/write and chooses which latched events may reach the parent line of that group. The number of groups is a parameter from 1 to 8, so the block covers up to 256 vectors and drives up to 8 parent lines.

Vector `n` lands in group `n/32`, at bit `n mod 32`. Software reaches the words through a word-addressed register port. The latch word of group `g` is at word address `g`. The mask word of group `g` is at word address `8 + g`, which is byte offset 0x20 + 4*g. The port never stalls: a write takes effect at the clock edge where it is presented. A read returns its data one cycle later, marked by a valid pulse. There is no back-pressure on either the event inputs or the register port, because every event is absorbed into its latch bit in a single cycle.

Top module: `ivc_top`

## Requirements
- R1: A one-cycle high on `vec_evt[n]` at a clock edge sets latch bit `n mod 32` of group `n/32` at that edge. The bit stays set until software clears it.
- R2: A write to word address `g` (g < NUM_GROUPS) clears every latch bit of group `g` whose write-data bit is 1. Latch bits whose write-data bit is 0 are left unchanged.
- R3: A write to word address `8 + g` (g < NUM_GROUPS) loads the mask word of group `g`. A later read of that address returns the written value.
- R4: An event on a vector whose mask bit is 0 still sets its latch bit. It does not raise the parent line of its group.
- R5: `parent_irq[g]` is high exactly when some bit of group `g` is both latched and unmasked. It follows the latch and mask registers in the cycle after the edge that changes them.
- R6: After reset, every latch bit and every mask bit is 0, all parent lines are low, and `reg_rvalid` is low.
- R7: When an event and a write-one clear hit the same latch bit at the same edge, the bit ends up set.
- R8: A read of an address that maps to no implemented word returns 0. A write to such an address changes no latch or mask word.
- R9: `reg_rvalid` is high in exactly the cycle after a cycle with `reg_rd` high. `reg_rdata` then carries the register value from before that edge, so a read and a write to the same word in the same cycle return the old value.
- R10: The parent line of each group depends only on that group's latch and mask words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_evt | input | NUM_GROUPS*32 | Per-vector event pulses; high at an edge records one event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | High in the cycle after a read strobe |
| parent_irq | output | NUM_GROUPS | One summary interrupt line per group |

## Verification
The bench sends events to both masked and unmasked vectors. This separates latching from the masking of the parent line, and shows which group's line rises. Write-one clears with mixed one and zero bits show that only the selected bits drop, and that the parent line falls only when the last unmasked bit goes. A clear that lands in the same cycle as a new event on that bit, and a read paired with a write to the same word, pin down the ordering at a single edge. Writes and reads to unimplemented group addresses, followed by reads of the real words, show that those addresses are inert.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int GRP_BITS   = 32;  // vectors per group, fixed by the register map
  localparam int MAX_GROUPS = 8;
  localparam int MASK_WORD0 = 8;   // word index of the first mask word (byte 0x20)
  localparam int ADDR_BITS  = 6;

  typedef logic [GRP_BITS-1:0] grp_word_t;
endpackage

// File: rtl/ivc_group.sv
module ivc_group
  import ivc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  grp_word_t evt,
  input  grp_word_t clr,
  input  logic      mask_we,
  input  grp_word_t mask_wdata,
  output grp_word_t latch_q,
  output grp_word_t mask_q,
  output logic      irq
);

  grp_word_t latch_d;

  // a clear and a fresh event on the same bit leave the bit set
  always_comb latch_d = (latch_q & ~clr) | evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      mask_q  <= '0;
    end else begin
      latch_q <= latch_d;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign irq = |(latch_q & mask_q);

  // R1: every event bit is latched at the next edge
  assert_evt_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((latch_q & $past(evt)) == $past(evt)));

  // R1: a latched bit that is not cleared is held
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  // R2: cleared bits without a coincident event drop
  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((latch_q & $past(clr) & ~$past(evt)) == '0));

  // R7: an event beats a clear on the same bit
  assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & evt) != '0) |=> ((latch_q & $past(clr & evt)) == $past(clr & evt)));

  // R4/R5: an event on an unmasked bit raises the line
  assert_unmasked_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((evt & mask_q) != '0) && !mask_we) |=> irq);

  // R5: nothing latched means no line
  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q == '0) |-> !irq);

  // R3: mask word loads the written value
  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata)));

endmodule

// File: rtl/ivc_regbus.sv
module ivc_regbus
  import ivc_pkg::*;
#(
  parameter int NUM_GROUPS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [ADDR_BITS-1:0]           reg_addr,
  input  grp_word_t                      reg_wdata,
  input  logic [NUM_GROUPS*GRP_BITS-1:0] latch_flat,
  input  logic [NUM_GROUPS*GRP_BITS-1:0] mask_flat,
  output logic [NUM_GROUPS*GRP_BITS-1:0] clr_flat,
  output logic [NUM_GROUPS-1:0]          mask_we,
  output grp_word_t                      reg_rdata,
  output logic                           reg_rvalid
);

  grp_word_t rd_word;
  logic      rd_hit;

  always_comb begin
    clr_flat = '0;
    mask_we  = '0;
    rd_word  = '0;
    rd_hit   = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr == ADDR_BITS'(g)) begin
        rd_word = latch_flat[g*GRP_BITS +: GRP_BITS];
        rd_hit  = 1'b1;
        if (reg_wr) clr_flat[g*GRP_BITS +: GRP_BITS] = reg_wdata;
      end
      if (reg_addr == ADDR_BITS'(MASK_WORD0 + g)) begin
        rd_word = mask_flat[g*GRP_BITS +: GRP_BITS];
        rd_hit  = 1'b1;
        mask_we[g] = reg_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_word;
    end
  end

  // R9: read valid follows the strobe by one cycle
  assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  assert_rvalid_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R8: unmapped reads return zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !rd_hit) |=> (reg_rdata == '0));

  // R8: unmapped writes reach no word
  assert_unmapped_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !rd_hit) |-> ((mask_we == '0) && (clr_flat == '0)));

  // R3: at most one mask word written per cycle
  assert_one_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_we));

endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NUM_GROUPS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_GROUPS*GRP_BITS-1:0]   vec_evt,
  input  logic                             reg_wr,
  input  logic                             reg_rd,
  input  logic [ADDR_BITS-1:0]             reg_addr,
  input  logic [GRP_BITS-1:0]              reg_wdata,
  output logic [GRP_BITS-1:0]              reg_rdata,
  output logic                             reg_rvalid,
  output logic [NUM_GROUPS-1:0]            parent_irq
);

  localparam int NUM_VEC = NUM_GROUPS * GRP_BITS;

  logic [NUM_VEC-1:0]    latch_flat;
  logic [NUM_VEC-1:0]    mask_flat;
  logic [NUM_VEC-1:0]    clr_flat;
  logic [NUM_GROUPS-1:0] mask_we;

  ivc_regbus #(.NUM_GROUPS(NUM_GROUPS)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .latch_flat (latch_flat),
    .mask_flat  (mask_flat),
    .clr_flat   (clr_flat),
    .mask_we    (mask_we),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    ivc_group u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (vec_evt[g*GRP_BITS +: GRP_BITS]),
      .clr        (clr_flat[g*GRP_BITS +: GRP_BITS]),
      .mask_we    (mask_we[g]),
      .mask_wdata (reg_wdata),
      .latch_q    (latch_flat[g*GRP_BITS +: GRP_BITS]),
      .mask_q     (mask_flat[g*GRP_BITS +: GRP_BITS]),
      .irq        (parent_irq[g])
    );
  end

  // R6: the cycle after reset all lines are low
  assert_reset_quiet_R6: assert property (@(posedge clk)
    !rst_n |=> (parent_irq == '0 && !reg_rvalid));

endmodule

// File: tb/ivc_top_test.sv
module ivc_top_test;
  localparam int NG = 3;
  localparam int NV = NG * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] vec_evt = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_rvalid;
  logic [NG-1:0] parent_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  ivc_top #(.NUM_GROUPS(NG)) uut (
    .clk(clk), .rst_n(rst_n), .vec_evt(vec_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .parent_irq(parent_irq)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read data act=%h exp=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    vec_evt[n] = 1'b1;
    @(negedge clk);
    vec_evt = '0;
  endtask

  task automatic check_irq(input logic [NG-1:0] e, input string t);
    checks++;
    if (parent_irq !== e) begin
      errors++;
      $display("FAIL %s parent_irq act=%b exp=%b", t, parent_irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_irq(3'b000, "R6 lines low after reset");
    checks++;
    if (reg_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R6 rvalid act=%b exp=0", reg_rvalid);
    end
    do_read(6'd0, 32'h0, "R6 latch0 reset");
    do_read(6'd9, 32'h0, "R6 mask1 reset");

    do_write(6'd9, 32'hFFFF_0000);
    do_read(6'd9, 32'hFFFF_0000, "R3 mask1 readback");

    pulse(32 + 3);  // masked vector
    check_irq(3'b000, "R4 masked event keeps line low");
    do_read(6'd1, 32'h0000_0008, "R4 masked event latched");

    pulse(32 + 20);  // unmasked vector
    check_irq(3'b010, "R5 R10 unmasked event raises own line");
    do_read(6'd1, 32'h0010_0008, "R1 both bits latched");
    repeat (5) @(negedge clk);
    do_read(6'd1, 32'h0010_0008, "R1 bits held");

    do_write(6'd1, 32'h0000_0008);
    do_read(6'd1, 32'h0010_0000, "R2 only written bit cleared");
    check_irq(3'b010, "R5 line held by remaining bit");
    do_write(6'd1, 32'h0010_0000);
    check_irq(3'b000, "R5 line drops when last unmasked bit cleared");

    // event and clear on the same bit at one edge
    vec_evt[5] = 1'b1;
    do_write(6'd0, 32'h0000_0020);
    vec_evt = '0;
    do_read(6'd0, 32'h0000_0020, "R7 event wins over clear");
    do_write(6'd0, 32'h0);
    do_read(6'd0, 32'h0000_0020, "R2 zero bits leave latch");

    // unimplemented addresses
    do_write(6'd4, 32'hFFFF_FFFF);
    do_write(6'd12, 32'hFFFF_FFFF);
    do_write(6'd20, 32'hFFFF_FFFF);
    do_read(6'd4, 32'h0, "R8 unmapped latch word");
    do_read(6'd12, 32'h0, "R8 unmapped mask word");
    do_read(6'd20, 32'h0, "R8 unused offset");
    do_read(6'd0, 32'h0000_0020, "R8 latch0 untouched");
    do_read(6'd8, 32'h0, "R8 mask0 untouched");
    check_irq(3'b000, "R8 no line raised");

    // read and write same word same cycle
    exp_q.push_back(32'h0);
    tag_q.push_back("R9 read returns pre-write value");
    reg_rd = 1'b1; reg_wr = 1'b1; reg_addr = 6'd8; reg_wdata = 32'h0000_000A;
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0;
    do_read(6'd8, 32'h0000_000A, "R9 R3 new value visible");

    do_write(6'd10, 32'h0000_0001);
    pulse(64);
    check_irq(3'b100, "R10 group2 line only");
    do_read(6'd2, 32'h0000_0001, "R1 group2 latch");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing reads act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule